// File: doc/BRIEF.md
# MMU Command and Status Register Unit

This block is the software-facing control front of a device-side address translation unit. It decodes 32-bit reads and writes on a simple single-cycle register bus and holds the page directory base. It executes the command codes that turn translation on and off, stall and release the translation engine, flush its cache and acknowledge page faults. It also reports the live status of the unit. The translation engine sits beside it: the engine receives paging, stall and cache-flush controls, and it returns fault and bus-error event pulses.

The unit captures the virtual address and the direction of the first page fault. It holds them until software acknowledges the fault. Fault and bus-error events are latched in a raw interrupt register. A mask selects which of them drive the interrupt line, and a write-one-to-clear register retires them. A hard-reset command returns every register to its power-on value without touching the reset pin.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: A write to word offset 0x00 stores only bits [31:12] of the data. Bits [11:0] always read as zero, so writing 0xCAFEBABE reads back 0xCAFEB000.
- R2: Command 0 written to offset 0x08 sets paging and command 1 clears it. Both take effect one cycle after the write, on `paging_o` and on status bit 0 (offset 0x04).
- R3: Command 2 sets the stall request only while paging is on and no fault is active. Command 3 clears the stall request. `stall_o` is the stall request OR fault-active. Status bit 2 is `stall_o` OR paging-off, and status bit 31 is its inverse.
- R4: A `fault_i` pulse while no fault is active sets fault-active (status bit 1). It also captures `fault_addr_i` at offset 0x0C and `fault_write_i` in status bit 5. Further faults leave both held while the fault stays active.
- R5: Command 5 clears fault-active. If a fault pulse arrives in the same cycle, the new fault is taken and captured.
- R6: Command 4 raises `zap_o` for exactly the following cycle. A write to offset 0x10 raises `zap_line_o` for the following cycle and presents the written word on `zap_line_addr_o`.
- R7: Raw interrupt status at offset 0x14 sets bit 0 on `fault_i` and bit 1 on `bus_err_i`. Writing 1 to a bit at offset 0x18 clears that raw bit, and an event in the same cycle wins. Offsets 0x08, 0x10 and 0x18 read as zero.
- R8: The mask at offset 0x1C (bits [1:0]) is read/write. Offset 0x20 reads raw AND mask, and `irq_o` is the OR of those bits.
- R9: Command 6 returns every register to its reset value: directory base, paging, stall, fault state and address, raw, mask, auto-gating, and the line-flush address.
- R10: Status bits 3 and 4 follow `idle_i` and `replay_empty_i`. The other status bits read zero. A command word other than 0 to 6 has no effect.
- R11: Bit 0 at offset 0x24 is read/write and drives `auto_gate_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| paging_o | output | 1 | Translation enabled |
| stall_o | output | 1 | Hold the translation engine |
| zap_o | output | 1 | One-cycle whole-cache flush |
| zap_line_o | output | 1 | One-cycle single-line flush |
| zap_line_addr_o | output | 32 | Address of the line to flush |
| auto_gate_o | output | 1 | Auto clock-gating enable |
| fault_i | input | 1 | Page fault event pulse |
| fault_addr_i | input | 32 | Faulting virtual address |
| fault_write_i | input | 1 | Faulting access was a write |
| bus_err_i | input | 1 | Read bus error event pulse |
| idle_i | input | 1 | Engine idle |
| replay_empty_i | input | 1 | Engine replay buffer empty |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that bus accesses are word aligned and that `fault_addr_i` is meaningful only in the cycle `fault_i` is high. They also assume that at most one register write is presented per cycle. The random stimulus draws addresses only from the ten defined word offsets. It keeps hard-reset commands rare so that state can build up between them. It lets fault, bus-error, clear and fault-done writes land in the same cycle, so that the event-wins rules are exercised.

// File: rtl/mmu_reg_pkg.sv
package mmu_reg_pkg;
  localparam int NSRC    = 2;
  localparam int DIR_LSB = 12;

  typedef enum logic [3:0] {
    REG_DIR   = 4'd0,
    REG_STAT  = 4'd1,
    REG_CMD   = 4'd2,
    REG_FADDR = 4'd3,
    REG_ZLINE = 4'd4,
    REG_RAW   = 4'd5,
    REG_CLR   = 4'd6,
    REG_MASK  = 4'd7,
    REG_MSTAT = 4'd8,
    REG_GATE  = 4'd9
  } reg_idx_e;

  typedef enum logic [2:0] {
    CMD_PG_ON     = 3'd0,
    CMD_PG_OFF    = 3'd1,
    CMD_STALL_ON  = 3'd2,
    CMD_STALL_OFF = 3'd3,
    CMD_ZAP       = 3'd4,
    CMD_FLT_DONE  = 3'd5,
    CMD_HRST      = 3'd6,
    CMD_NONE      = 3'd7
  } cmd_e;
endpackage

// File: rtl/mmu_cmd_ctrl.sv
module mmu_cmd_ctrl
  import mmu_reg_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cmd_vld_i,
  input  cmd_e            cmd_i,
  input  logic            flt_i,
  input  logic [VA_W-1:0] flt_addr_i,
  input  logic            flt_wr_i,
  output logic            paging_o,
  output logic            stall_req_o,
  output logic            flt_act_o,
  output logic [VA_W-1:0] flt_addr_o,
  output logic            flt_wr_o,
  output logic            zap_o
);
  logic done;
  assign done = cmd_vld_i && (cmd_i == CMD_FLT_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paging_o    <= 1'b0;
      stall_req_o <= 1'b0;
      flt_act_o   <= 1'b0;
      flt_addr_o  <= '0;
      flt_wr_o    <= 1'b0;
      zap_o       <= 1'b0;
    end else if (clr_i) begin
      paging_o    <= 1'b0;
      stall_req_o <= 1'b0;
      flt_act_o   <= 1'b0;
      flt_addr_o  <= '0;
      flt_wr_o    <= 1'b0;
      zap_o       <= 1'b0;
    end else begin
      zap_o <= cmd_vld_i && (cmd_i == CMD_ZAP);
      if (cmd_vld_i) begin
        case (cmd_i)
          CMD_PG_ON:     paging_o <= 1'b1;
          CMD_PG_OFF:    paging_o <= 1'b0;
          CMD_STALL_ON:  if (paging_o && !flt_act_o) stall_req_o <= 1'b1;
          CMD_STALL_OFF: stall_req_o <= 1'b0;
          default: ;
        endcase
      end
      // a new fault outranks an acknowledge in the same cycle
      if (flt_i && (!flt_act_o || done)) begin
        flt_act_o  <= 1'b1;
        flt_addr_o <= flt_addr_i;
        flt_wr_o   <= flt_wr_i;
      end else if (done) begin
        flt_act_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mmu_irq_bank.sv
module mmu_irq_bank #(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NSRC-1:0] ev_i,
  input  logic            ack_wr_i,
  input  logic            mask_wr_i,
  input  logic [NSRC-1:0] wbits_i,
  output logic [NSRC-1:0] raw_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        raw_o[s]  <= 1'b0;
        mask_o[s] <= 1'b0;
      end else if (clr_i) begin
        raw_o[s]  <= 1'b0;
        mask_o[s] <= 1'b0;
      end else begin
        if (ev_i[s])                      raw_o[s] <= 1'b1;
        else if (ack_wr_i && wbits_i[s])  raw_o[s] <= 1'b0;
        if (mask_wr_i)                    mask_o[s] <= wbits_i[s];
      end
    end
    assign pend_o[s] = raw_o[s] & mask_o[s];
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              paging_o,
  output logic              stall_o,
  output logic              zap_o,
  output logic              zap_line_o,
  output logic [31:0]       zap_line_addr_o,
  output logic              auto_gate_o,
  input  logic              fault_i,
  input  logic [31:0]       fault_addr_i,
  input  logic              fault_write_i,
  input  logic              bus_err_i,
  input  logic              idle_i,
  input  logic              replay_empty_i,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             wr_en, cmd_vld, hrst;
  cmd_e             cmd;
  logic [31:DIR_LSB] dir_q;
  logic             stall_req, flt_act, flt_wr, stall_bit;
  logic [31:0]      flt_addr;
  logic [NSRC-1:0]  raw, mask, pend;

  function automatic logic hit(input logic [IDX_W-1:0] idx, input reg_idx_e r);
    return idx == IDX_W'(r);
  endfunction

  assign widx    = addr_i[ADDR_W-1:2];
  assign wr_en   = req_i & we_i;
  assign cmd     = cmd_e'(wdata_i[2:0]);
  assign cmd_vld = wr_en && hit(widx, REG_CMD) && (wdata_i[31:3] == '0) && (cmd != CMD_NONE);
  assign hrst    = cmd_vld && (cmd == CMD_HRST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q           <= '0;
      auto_gate_o     <= 1'b0;
      zap_line_o      <= 1'b0;
      zap_line_addr_o <= '0;
    end else if (hrst) begin
      dir_q           <= '0;
      auto_gate_o     <= 1'b0;
      zap_line_o      <= 1'b0;
      zap_line_addr_o <= '0;
    end else begin
      zap_line_o <= wr_en && hit(widx, REG_ZLINE);
      if (wr_en && hit(widx, REG_DIR))   dir_q           <= wdata_i[31:DIR_LSB];
      if (wr_en && hit(widx, REG_GATE))  auto_gate_o     <= wdata_i[0];
      if (wr_en && hit(widx, REG_ZLINE)) zap_line_addr_o <= wdata_i;
    end
  end

  mmu_cmd_ctrl #(.VA_W(32)) i_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (hrst),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (cmd),
    .flt_i       (fault_i),
    .flt_addr_i  (fault_addr_i),
    .flt_wr_i    (fault_write_i),
    .paging_o    (paging_o),
    .stall_req_o (stall_req),
    .flt_act_o   (flt_act),
    .flt_addr_o  (flt_addr),
    .flt_wr_o    (flt_wr),
    .zap_o       (zap_o)
  );

  mmu_irq_bank #(.NSRC(NSRC)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (hrst),
    .ev_i      ({bus_err_i, fault_i}),
    .ack_wr_i  (wr_en && hit(widx, REG_CLR)),
    .mask_wr_i (wr_en && hit(widx, REG_MASK)),
    .wbits_i   (wdata_i[NSRC-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  assign stall_o   = stall_req | flt_act;
  assign stall_bit = stall_o | ~paging_o;

  always_comb begin
    rdata_o = '0;
    if (hit(widx, REG_DIR))        rdata_o = {dir_q, {DIR_LSB{1'b0}}};
    else if (hit(widx, REG_STAT))  rdata_o = {~stall_bit, 25'd0, flt_wr, replay_empty_i,
                                              idle_i, stall_bit, flt_act, paging_o};
    else if (hit(widx, REG_FADDR)) rdata_o = flt_addr;
    else if (hit(widx, REG_RAW))   rdata_o = 32'(raw);
    else if (hit(widx, REG_MASK))  rdata_o = 32'(mask);
    else if (hit(widx, REG_MSTAT)) rdata_o = 32'(pend);
    else if (hit(widx, REG_GATE))  rdata_o = {31'd0, auto_gate_o};
  end
endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
module mmu_ctrl_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              paging_o,
  input logic              stall_o,
  input logic              zap_o,
  input logic              irq_o,
  input logic              stall_req,
  input logic              flt_act,
  input logic [31:0]       flt_addr
);
  logic [ADDR_W-3:0] widx;
  logic rd, wcmd;
  assign widx = addr_i[ADDR_W-1:2];
  assign rd   = req_i && !we_i;
  assign wcmd = req_i && we_i && (widx == 2);

  // R1
  dir_lsb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && widx == 0) |-> (rdata_o[11:0] == 12'd0));

  // R2
  paging_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcmd && wdata_i == 32'd0) |=> paging_o);

  // R3
  stall_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcmd && wdata_i == 32'd2 && flt_act && !stall_req) |=> !stall_req);

  // R3
  stall_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_act |-> stall_o);

  // R4
  fault_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_act && !(wcmd && (wdata_i == 32'd5 || wdata_i == 32'd6))) |=> $stable(flt_addr));

  // R6
  zap_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcmd && wdata_i == 32'd4) |=> zap_o);

  // R6
  zap_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zap_o |-> $past(wcmd && wdata_i == 32'd4));

  // R8
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && widx == 8) |-> (irq_o == |rdata_o[1:0]));
endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .paging_o  (paging_o),
  .stall_o   (stall_o),
  .zap_o     (zap_o),
  .irq_o     (irq_o),
  .stall_req (stall_req),
  .flt_act   (flt_act),
  .flt_addr  (flt_addr)
);

// File: tb/test_mmu_ctrl_regs.sv
module test_mmu_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        paging, stall, zap, zline, gate, irq;
  logic [31:0] zline_addr;
  logic        flt = 1'b0, fwr = 1'b0, berr = 1'b0, idle = 1'b0, rep = 1'b0;
  logic [31:0] faddr = '0;

  int vectors = 0, miscmp = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_dir, m_faddr, m_zla;
  logic        m_pg, m_st, m_fa, m_fw, m_gate, m_zap, m_zl;
  logic [1:0]  m_raw, m_mask;

  always #5 clk = ~clk;

  mmu_ctrl_regs i_mmu_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .paging_o(paging), .stall_o(stall),
    .zap_o(zap), .zap_line_o(zline), .zap_line_addr_o(zline_addr),
    .auto_gate_o(gate), .fault_i(flt), .fault_addr_i(faddr),
    .fault_write_i(fwr), .bus_err_i(berr), .idle_i(idle),
    .replay_empty_i(rep), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_dir = '0; m_faddr = '0; m_zla = '0; m_pg = 0; m_st = 0; m_fa = 0;
    m_fw = 0; m_gate = 0; m_zap = 0; m_zl = 0; m_raw = '0; m_mask = '0;
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic sb;
    sb = m_st | m_fa | ~m_pg;
    case (a[7:2])
      6'd0: return m_dir;
      6'd1: return {~sb, 25'd0, m_fw, rep, idle, sb, m_fa, m_pg};
      6'd3: return m_faddr;
      6'd5: return {30'd0, m_raw};
      6'd7: return {30'd0, m_mask};
      6'd8: return {30'd0, m_raw & m_mask};
      6'd9: return {31'd0, m_gate};
      default: return 32'd0;
    endcase
  endfunction

  // apply one cycle of stimulus, then update the model from the requirements
  task automatic step(input string tag, input bit w, input logic [7:0] a, input logic [31:0] d,
                      input bit f, input logic [31:0] fa, input bit fw_in, input bit be);
    bit isc, done;
    logic [2:0] c;
    @(negedge clk);
    req = w; we = w; addr = a; wdata = d; flt = f; faddr = fa; fwr = fw_in; berr = be;
    @(posedge clk);
    isc  = w && a[7:2] == 6'd2 && d[31:3] == 0 && d[2:0] != 3'd7;
    c    = d[2:0];
    done = isc && c == 3'd5;
    if (isc && c == 3'd6) m_reset();
    else begin
      m_zap = isc && c == 3'd4;
      m_zl  = w && a[7:2] == 6'd4;
      if (m_zl) m_zla = d;
      if (w && a[7:2] == 6'd0) m_dir = d & 32'hFFFF_F000;
      if (w && a[7:2] == 6'd7) m_mask = d[1:0];
      if (w && a[7:2] == 6'd9) m_gate = d[0];
      if (w && a[7:2] == 6'd6) m_raw = m_raw & ~d[1:0];
      m_raw = m_raw | {be, f};
      if (isc && c == 3'd2 && m_pg && !m_fa) m_st = 1;
      if (isc && c == 3'd3) m_st = 0;
      if (f && (!m_fa || done)) begin
        m_fa = 1; m_faddr = fa; m_fw = fw_in;
      end else if (done) m_fa = 0;
      if (isc && c == 3'd0) m_pg = 1;
      if (isc && c == 3'd1) m_pg = 0;
    end
    #2;
    chk({tag, " R2 paging_o"}, {31'd0, paging}, {31'd0, m_pg});
    chk({tag, " R3 stall_o"}, {31'd0, stall}, {31'd0, m_st | m_fa});
    chk({tag, " R6 zap_o"}, {31'd0, zap}, {31'd0, m_zap});
    chk({tag, " R6 zap_line_o"}, {31'd0, zline}, {31'd0, m_zl});
    if (m_zl) chk({tag, " R6 zap_line_addr_o"}, zline_addr, m_zla);
    chk({tag, " R11 auto_gate_o"}, {31'd0, gate}, {31'd0, m_gate});
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    req = 1; we = 0; addr = a; wdata = '0; flt = 0; berr = 0; fwr = 0;
    #1;
    chk({tag, " rdata"}, rdata, exp_read(a));
    chk({tag, " R8 irq_o"}, {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d);
    step(tag, 1, a, d, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscmp++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};
    void'($urandom(32'h0C0FFEE5));
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // reset state
    rd("R9 reset dir", 8'h00);
    rd("R3 reset status", 8'h04);
    rd("R7 reset raw", 8'h14);

    // R1 low bits masked
    wr("R1", 8'h00, 32'hCAFEBABE);
    rd("R1 dir readback", 8'h00);
    chk("R1 literal", rdata, 32'hCAFEB000);

    // R10 status inputs and unknown command
    idle = 1; rep = 1;
    rd("R10 status idle", 8'h04);
    wr("R10 unknown cmd", 8'h08, 32'd7);
    wr("R10 wide cmd", 8'h08, 32'h0000_0100);
    rd("R10 unchanged", 8'h04);

    // R3 stall ignored while paging off
    wr("R3 stall off-paging", 8'h08, 32'd2);
    rd("R3 implicit stall", 8'h04);
    wr("R2 paging on", 8'h08, 32'd0);
    rd("R2 status", 8'h04);
    wr("R3 stall on", 8'h08, 32'd2);
    rd("R3 stall status", 8'h04);
    wr("R3 stall off", 8'h08, 32'd3);
    rd("R3 release", 8'h04);

    // R4 fault capture and hold, R3 stall gated during fault
    wr("R8 mask", 8'h1C, 32'd3);
    step("R4 fault", 0, 8'h00, 0, 1, 32'h1234_5678, 1, 0);
    rd("R4 fault addr", 8'h0C);
    step("R4 second fault", 0, 8'h00, 0, 1, 32'h9999_0000, 0, 0);
    rd("R4 held addr", 8'h0C);
    rd("R4 status", 8'h04);
    wr("R3 stall during fault", 8'h08, 32'd2);
    wr("R5 done", 8'h08, 32'd5);
    rd("R3 stall not taken", 8'h04);

    // R5 simultaneous fault and done
    step("R4 fault2", 0, 8'h00, 0, 1, 32'hAAAA_0000, 0, 0);
    step("R5 fault vs done", 1, 8'h08, 32'd5, 1, 32'hBBBB_1000, 1, 0);
    rd("R5 new fault wins", 8'h0C);
    rd("R5 status", 8'h04);

    // R7 clear versus event
    step("R7 berr", 0, 8'h00, 0, 0, 0, 0, 1);
    rd("R7 raw", 8'h14);
    step("R7 clear vs event", 1, 8'h18, 32'd3, 0, 0, 0, 1);
    rd("R7 event wins", 8'h14);
    wr("R7 clear", 8'h18, 32'd2);
    rd("R7 cleared", 8'h14);
    rd("R8 masked", 8'h20);

    // R6 strobes, R11 gate
    wr("R6 zap", 8'h08, 32'd4);
    wr("R6 zap line", 8'h10, 32'h0040_3000);
    wr("R11 gate", 8'h24, 32'd1);
    rd("R11 gate read", 8'h24);

    // R9 hard reset
    wr("R9 hard reset", 8'h08, 32'd6);
    for (int i = 0; i < 10; i++) rd("R9 after reset", offs[i]);

    // random phase
    for (int n = 0; n < 600; n++) begin
      bit w, f, be;
      logic [7:0] a;
      logic [31:0] d;
      w = ($urandom % 3) != 0;
      a = offs[$urandom % 10];
      d = $urandom;
      if (a == 8'h08) begin
        d = $urandom % 8;
        if (d == 6 && ($urandom % 8) != 0) d = 5;
      end
      f  = ($urandom % 6) == 0;
      be = ($urandom % 8) == 0;
      idle = $urandom; rep = $urandom;
      step("rand", w, a, d, f, $urandom, $urandom, be);
      rd("rand R4 R7", offs[$urandom % 10]);
      rd("rand R3 status", 8'h04);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule